// File: doc/BRIEF.md
# Parallel Flash Block Program Sequencer

This block writes one block of bytes, already sitting in a local buffer, into an 8-bit parallel flash device that is driven by written command bytes. A host pulses `start` with the block's base address. The block then runs the whole exchange with the device on its own. It puts the device into array-read mode and checks the identity bytes twice. It clears status, erases the block and programs every byte, waiting on the ready flag after each step. Last, it returns the device to array-read mode and reads the whole block back against the buffer.

The outcome arrives as a one-clock `done` pulse. With it come an error flag, a two-bit error code and, for a read-back miscompare, the offset of the first byte that differs. Every flash bus cycle holds its strobe low for a fixed number of clocks. Between cycles there is always a clock with the chip deselected.

Top module: `fblk_prog_seq`

## Requirements
- R1: During and directly after reset, `fl_ce_n`, `fl_we_n` and `fl_oe_n` are high, and `done`, `err` and `err_code` are 0.
- R2: After `start` the first bus cycle writes 0xFF to the block base address. Then the identity probe runs twice. Each probe writes 0x90 to the base address, reads device address 0 (manufacturer, expected 0xB0), reads device address 1 (device, expected 0x5A) and writes 0xFF to the base address.
- R3: If either identity byte differs in a probe, the sequence ends after that probe's closing 0xFF write. It ends with `done`, `err`=1 and `err_code`=1, and no erase or program cycle is issued.
- R4: After two good probes, the following writes go to the base address in this order: 0x50, 0xFF, 0x20, 0xD0.
- R5: After the 0xD0 erase confirm, and after every programmed data byte, the base address is read repeatedly until a read returns bit 7 set. Only bit 7 decides readiness (0x7F counts as busy).
- R6: Each byte i of the block, in ascending order, is written as 0x40 to the base address and then buffer byte i to base+i. The buffer is read through `buf_addr`/`buf_data`.
- R7: After the last byte is ready, 0xFF is written to the base address and base+i is read for ascending i. If all bytes match, the block pulses `done` for exactly one clock with `err`=0 and `err_code`=0.
- R8: On the first read-back byte that differs from the buffer, reading stops. `done` pulses with `err`=1, `err_code`=3 and `err_offset` set to that byte's offset.
- R9: If POLL_LIMIT consecutive status reads all have bit 7 clear, the sequence stops after the last of them. `done` pulses with `err`=1 and `err_code`=2, and `err_offset` holds the current byte offset (0 during erase).
- R10: Each bus cycle drives `fl_ce_n` low together with exactly one of `fl_we_n` or `fl_oe_n` for STROBE_CLKS clocks. Address and write data stay stable while the strobe is low, and at least one clock with `fl_ce_n` high follows every cycle.
- R11: A `start` pulse while a sequence is in progress is ignored. The running sequence's bus cycles and result are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a block write (taken only when idle) |
| blk_addr | input | ADDR_W | Flash base address of the block, sampled with `start` |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | Completion was an error (valid with `done`, held until next start) |
| err_code | output | 2 | 0 none, 1 identity mismatch, 2 ready timeout, 3 read-back mismatch |
| err_offset | output | log2(BLK_BYTES) | Offset of the failing byte |
| buf_addr | output | log2(BLK_BYTES) | Block buffer read address |
| buf_data | input | 8 | Block buffer read data (combinational) |
| fl_addr | output | ADDR_W | Flash address |
| fl_dout | output | 8 | Flash write data |
| fl_din | input | 8 | Flash read data |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_oe_n | output | 1 | Flash read strobe, active low |

## Verification
The main function runs against a bench flash model with several buffer patterns: a stride pattern, alternating 0x55/0xAA, a descending ramp and all zeros. The model programs by AND-ing into old contents. A missing erase, or a byte written to the wrong address, therefore shows up at read-back. Miscompares are injected at offset 0, at offset 37 and at the last offset, so the reported offset and the early stop are told apart from a full pass. Ready delays of zero and several busy reads, with busy returned as 0x7F, separate a bit-7 test from a whole-byte test. A device that never becomes ready, a wrong device identity and a start pulse in mid-run cover the abort paths and the busy guard.

// File: rtl/fblk_pkg.sv
package fblk_pkg;

    localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
    localparam logic [7:0] CMD_READ_ID    = 8'h90;
    localparam logic [7:0] CMD_CLR_STATUS = 8'h50;
    localparam logic [7:0] CMD_ERASE      = 8'h20;
    localparam logic [7:0] CMD_CONFIRM    = 8'hD0;
    localparam logic [7:0] CMD_PROGRAM    = 8'h40;
    localparam logic [7:0] ID_MFR         = 8'hB0;
    localparam logic [7:0] ID_DEV         = 8'h5A;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_ID      = 2'd1,
        ERR_TIMEOUT = 2'd2,
        ERR_VERIFY  = 2'd3
    } fblk_err_e;

    typedef enum logic { XFER_RD = 1'b0, XFER_WR = 1'b1 } xfer_kind_e;

    typedef enum logic [1:0] { PH_IDLE, PH_STROBE, PH_GAP } bus_phase_e;

    typedef enum logic [3:0] {
        S_IDLE, S_RST, S_IDCMD, S_IDMFR, S_IDDEV, S_IDEXIT,
        S_CLR, S_CLRFF, S_ERA1, S_ERA2, S_POLL,
        S_PCMD, S_PDAT, S_VFF, S_VRD
    } seq_state_e;

    typedef struct packed {
        xfer_kind_e kind;
        logic [7:0] wdata;
    } xfer_t;

    function automatic logic dev_ready(input logic [7:0] status);
        return status[7];
    endfunction

endpackage

// File: rtl/fblk_bus.sv
module fblk_bus
    import fblk_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int STROBE_CLKS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  xfer_t             xfer,
    input  logic [ADDR_W-1:0] xaddr,
    output logic              ack,
    output logic [7:0]        rdata,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_dout,
    output logic              fl_ce_n,
    output logic              fl_we_n,
    output logic              fl_oe_n,
    input  logic [7:0]        fl_din
);

    localparam int CNT_W = (STROBE_CLKS > 1) ? $clog2(STROBE_CLKS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_CLKS - 1);

    bus_phase_e       phase;
    xfer_kind_e       kind;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            kind    <= XFER_RD;
            cnt     <= '0;
            fl_addr <= '0;
            fl_dout <= '0;
            rdata   <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (req) begin
                        kind    <= xfer.kind;
                        fl_addr <= xaddr;
                        fl_dout <= xfer.wdata;
                        cnt     <= '0;
                        phase   <= PH_STROBE;
                    end
                end
                PH_STROBE: begin
                    if (cnt == CNT_LAST) begin
                        if (kind == XFER_RD) rdata <= fl_din;
                        phase <= PH_GAP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign ack     = (phase == PH_GAP);
    assign fl_ce_n = (phase != PH_STROBE);
    assign fl_we_n = !((phase == PH_STROBE) && (kind == XFER_WR));
    assign fl_oe_n = !((phase == PH_STROBE) && (kind == XFER_RD));

endmodule

// File: rtl/fblk_poll_ctr.sv
module fblk_poll_ctr #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic last
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (inc)   cnt <= cnt + 1'b1;
    end

    assign last = (cnt == CW'(LIMIT - 1));

endmodule

// File: rtl/fblk_seq.sv
module fblk_seq
    import fblk_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BLK_BYTES = 256,
    parameter int OFF_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] blk_addr,
    output logic              done,
    output logic              err,
    output fblk_err_e         err_code,
    output logic [OFF_W-1:0]  err_offset,
    output logic [OFF_W-1:0]  buf_addr,
    input  logic [7:0]        buf_data,
    output logic              req,
    output xfer_t             xfer,
    output logic [ADDR_W-1:0] xaddr,
    input  logic              ack,
    input  logic [7:0]        rdata,
    output logic              poll_clr,
    output logic              poll_inc,
    input  logic              poll_last
);

    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(BLK_BYTES - 1);

    seq_state_e        state;
    logic [ADDR_W-1:0] base;
    logic [OFF_W-1:0]  off;
    logic              second_pass;
    logic              id_ok;
    logic              programming;
    logic [ADDR_W-1:0] byte_addr;

    assign byte_addr = base + ADDR_W'(off);
    assign buf_addr  = off;
    assign poll_clr  = ack && ((state == S_ERA2) || (state == S_PDAT));
    assign poll_inc  = ack && (state == S_POLL) && !dev_ready(rdata);

    always_comb begin
        req        = 1'b1;
        xfer.kind  = XFER_WR;
        xfer.wdata = CMD_READ_ARRAY;
        xaddr      = base;
        case (state)
            S_IDCMD: xfer.wdata = CMD_READ_ID;
            S_IDMFR: begin xfer.kind = XFER_RD; xaddr = '0; end
            S_IDDEV: begin xfer.kind = XFER_RD; xaddr = ADDR_W'(1); end
            S_CLR:   xfer.wdata = CMD_CLR_STATUS;
            S_ERA1:  xfer.wdata = CMD_ERASE;
            S_ERA2:  xfer.wdata = CMD_CONFIRM;
            S_POLL:  xfer.kind = XFER_RD;
            S_PCMD:  xfer.wdata = CMD_PROGRAM;
            S_PDAT:  begin xfer.wdata = buf_data; xaddr = byte_addr; end
            S_VRD:   begin xfer.kind = XFER_RD; xaddr = byte_addr; end
            S_RST, S_IDEXIT, S_CLRFF, S_VFF: ;
            default: req = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= S_IDLE;
            base        <= '0;
            off         <= '0;
            second_pass <= 1'b0;
            id_ok       <= 1'b0;
            programming <= 1'b0;
            done        <= 1'b0;
            err         <= 1'b0;
            err_code    <= ERR_NONE;
            err_offset  <= '0;
        end else begin
            done <= 1'b0;
            if (state == S_IDLE) begin
                if (start) begin
                    base        <= blk_addr;
                    off         <= '0;
                    second_pass <= 1'b0;
                    programming <= 1'b0;
                    err         <= 1'b0;
                    err_code    <= ERR_NONE;
                    err_offset  <= '0;
                    state       <= S_RST;
                end
            end else if (ack) begin
                case (state)
                    S_RST:   state <= S_IDCMD;
                    S_IDCMD: state <= S_IDMFR;
                    S_IDMFR: begin
                        id_ok <= (rdata == ID_MFR);
                        state <= S_IDDEV;
                    end
                    S_IDDEV: begin
                        id_ok <= id_ok && (rdata == ID_DEV);
                        state <= S_IDEXIT;
                    end
                    S_IDEXIT: begin
                        if (!id_ok) begin
                            done     <= 1'b1;
                            err      <= 1'b1;
                            err_code <= ERR_ID;
                            state    <= S_IDLE;
                        end else if (!second_pass) begin
                            second_pass <= 1'b1;
                            state       <= S_IDCMD;
                        end else begin
                            state <= S_CLR;
                        end
                    end
                    S_CLR:   state <= S_CLRFF;
                    S_CLRFF: state <= S_ERA1;
                    S_ERA1:  state <= S_ERA2;
                    S_ERA2:  state <= S_POLL;
                    S_POLL: begin
                        if (dev_ready(rdata)) begin
                            if (!programming) begin
                                programming <= 1'b1;
                                state       <= S_PCMD;
                            end else if (off == LAST_OFF) begin
                                off   <= '0;
                                state <= S_VFF;
                            end else begin
                                off   <= off + 1'b1;
                                state <= S_PCMD;
                            end
                        end else if (poll_last) begin
                            done       <= 1'b1;
                            err        <= 1'b1;
                            err_code   <= ERR_TIMEOUT;
                            err_offset <= off;
                            state      <= S_IDLE;
                        end
                    end
                    S_PCMD: state <= S_PDAT;
                    S_PDAT: state <= S_POLL;
                    S_VFF:  state <= S_VRD;
                    S_VRD: begin
                        if (rdata != buf_data) begin
                            done       <= 1'b1;
                            err        <= 1'b1;
                            err_code   <= ERR_VERIFY;
                            err_offset <= off;
                            state      <= S_IDLE;
                        end else if (off == LAST_OFF) begin
                            done  <= 1'b1;
                            state <= S_IDLE;
                        end else begin
                            off <= off + 1'b1;
                        end
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/fblk_prog_seq.sv
module fblk_prog_seq
    import fblk_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int BLK_BYTES   = 256,
    parameter int STROBE_CLKS = 2,
    parameter int POLL_LIMIT  = 64
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic [ADDR_W-1:0]            blk_addr,
    output logic                         done,
    output logic                         err,
    output logic [1:0]                   err_code,
    output logic [$clog2(BLK_BYTES)-1:0] err_offset,
    output logic [$clog2(BLK_BYTES)-1:0] buf_addr,
    input  logic [7:0]                   buf_data,
    output logic [ADDR_W-1:0]            fl_addr,
    output logic [7:0]                   fl_dout,
    input  logic [7:0]                   fl_din,
    output logic                         fl_ce_n,
    output logic                         fl_we_n,
    output logic                         fl_oe_n
);

    localparam int OFF_W = $clog2(BLK_BYTES);

    xfer_t             xfer;
    logic              req;
    logic              ack;
    logic [ADDR_W-1:0] xaddr;
    logic [7:0]        rdata;
    logic              poll_clr;
    logic              poll_inc;
    logic              poll_last;
    fblk_err_e         code_e;

    assign err_code = code_e;

    fblk_seq #(
        .ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES), .OFF_W(OFF_W)
    ) u_seq (
        .clk(clk), .rst(rst), .start(start), .blk_addr(blk_addr),
        .done(done), .err(err), .err_code(code_e), .err_offset(err_offset),
        .buf_addr(buf_addr), .buf_data(buf_data),
        .req(req), .xfer(xfer), .xaddr(xaddr), .ack(ack), .rdata(rdata),
        .poll_clr(poll_clr), .poll_inc(poll_inc), .poll_last(poll_last)
    );

    fblk_bus #(
        .ADDR_W(ADDR_W), .STROBE_CLKS(STROBE_CLKS)
    ) u_bus (
        .clk(clk), .rst(rst), .req(req), .xfer(xfer), .xaddr(xaddr),
        .ack(ack), .rdata(rdata),
        .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_ce_n(fl_ce_n),
        .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_din(fl_din)
    );

    fblk_poll_ctr #(
        .LIMIT(POLL_LIMIT)
    ) u_poll (
        .clk(clk), .rst(rst), .clr(poll_clr), .inc(poll_inc), .last(poll_last)
    );

endmodule

// File: rtl/fblk_prog_seq_chk.sv
module fblk_prog_seq_chk #(
    parameter int ADDR_W      = 16,
    parameter int STROBE_CLKS = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              done,
    input logic              err,
    input logic [1:0]        err_code,
    input logic [ADDR_W-1:0] fl_addr,
    input logic [7:0]        fl_dout,
    input logic              fl_ce_n,
    input logic              fl_we_n,
    input logic              fl_oe_n
);

    int unsigned low_run;

    always_ff @(posedge clk) begin
        if (rst || fl_ce_n) low_run <= 0;
        else                low_run <= low_run + 1;
    end

    // R10: never both strobes at once
    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(!fl_we_n && !fl_oe_n));

    // R10: a selected chip always has a strobe active
    p_ce_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        !fl_ce_n |-> (!fl_we_n || !fl_oe_n));

    // R10: at least one deselected clock after every cycle
    p_gap_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(fl_ce_n) |=> fl_ce_n);

    // R10: strobe width
    p_width_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(fl_ce_n) |-> (low_run == STROBE_CLKS));

    // R10: address and data stable while writing
    p_wr_stable_r10: assert property (@(posedge clk) disable iff (rst)
        (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_dout) && $stable(fl_addr)));

    // R7: done is a single-clock pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: success reports code 0
    p_ok_code_r7: assert property (@(posedge clk) disable iff (rst)
        (done && !err) |-> (err_code == 2'd0));

    // R8: an error always carries a nonzero code
    p_err_code_r8: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> (err_code != 2'd0));

endmodule

bind fblk_prog_seq fblk_prog_seq_chk #(
    .ADDR_W(ADDR_W), .STROBE_CLKS(STROBE_CLKS)
) u_chk (
    .clk(clk), .rst(rst), .done(done), .err(err), .err_code(err_code),
    .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_ce_n(fl_ce_n),
    .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
);

// File: tb/fblk_prog_seq_test.sv
module fblk_prog_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW  = 16;
    localparam int BLK = 256;
    localparam int SC  = 2;
    localparam int PL  = 64;
    localparam int OW  = $clog2(BLK);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] blk_addr = '0;
    logic          done, err;
    logic [1:0]    err_code;
    logic [OW-1:0] err_offset, buf_addr;
    logic [7:0]    buf_data;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_dout;
    logic [7:0]    fl_din = 8'h00;
    logic          fl_ce_n, fl_we_n, fl_oe_n;

    logic [7:0] bufmem [BLK];
    assign buf_data = bufmem[buf_addr];

    fblk_prog_seq #(
        .ADDR_W(AW), .BLK_BYTES(BLK), .STROBE_CLKS(SC), .POLL_LIMIT(PL)
    ) uut (
        .clk(clk), .rst(rst), .start(start), .blk_addr(blk_addr),
        .done(done), .err(err), .err_code(err_code), .err_offset(err_offset),
        .buf_addr(buf_addr), .buf_data(buf_data),
        .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_din(fl_din),
        .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // ---------------- expected bus cycle list ----------------
    typedef struct {
        bit    wr;
        int    addr;
        int    data;
        string tag;
    } txn_t;
    txn_t exp_q[$];

    task automatic push(input bit wr, input int a, input int d, input string tag);
        txn_t t;
        t.wr = wr; t.addr = a; t.data = d; t.tag = tag;
        exp_q.push_back(t);
    endtask

    // ---------------- behavioural flash model ----------------
    logic [7:0] fmem [int];
    int  mode;          // 0 array, 1 identity, 2 status
    bit  pend_erase, pend_prog, stuck, bad_dev;
    int  busy, ebusy, pbusy, corrupt_off, cur_base;

    function automatic logic [7:0] model_read(input int a);
        if (mode == 1) return (a == 0) ? 8'hB0 : (bad_dev ? 8'h5B : 8'h5A);
        if (mode == 2) return (stuck || busy > 0) ? 8'h7F : 8'h80;
        return fmem.exists(a) ? fmem[a] : 8'hFF;
    endfunction

    task automatic model_write(input int a, input logic [7:0] d);
        logic [7:0] v;
        if (pend_prog) begin
            v = d;
            if (a - cur_base == corrupt_off) v = d ^ 8'h10;
            fmem[a] = (fmem.exists(a) ? fmem[a] : 8'hFF) & v;
            pend_prog = 0; mode = 2; busy = pbusy;
        end else if (pend_erase && d == 8'hD0) begin
            for (int i = 0; i < BLK; i++) fmem[a + i] = 8'hFF;
            pend_erase = 0; mode = 2; busy = ebusy;
        end else begin
            pend_erase = 0;
            case (d)
                8'hFF: mode = 0;
                8'h90: mode = 1;
                8'h20: pend_erase = 1;
                8'h40: pend_prog = 1;
                default: ;
            endcase
        end
    endtask

    task automatic log_txn(input bit wr, input int a, input int d);
        txn_t t;
        if (exp_q.size() == 0) begin
            chk(0, "R2", "unexpected bus cycle at address", a, -1);
        end else begin
            t = exp_q.pop_front();
            chk(t.wr == wr && t.addr == a && (!wr || t.data == d), t.tag,
                wr ? "write cycle {kind,addr,data}" : "read cycle {kind,addr}",
                (int'(wr) << 24) | (a << 8) | (wr ? d : 0),
                (int'(t.wr) << 24) | (t.addr << 8) | (t.wr ? t.data : 0));
        end
    endtask

    // ---------------- per-clock bus observation ----------------
    logic prev_we = 1'b1, prev_oe = 1'b1, prev_ce = 1'b1;
    bit   gap_due = 0;
    int   low_run = 0, lat_addr = 0;
    logic [7:0] lat_data = 8'h00;

    always @(negedge clk) begin
        cyc++;
        if (gap_due) begin
            chk(fl_ce_n, "R10", "idle clock after bus cycle", fl_ce_n, 1);
            gap_due = 0;
        end
        if (!fl_ce_n) low_run++;
        if (!fl_we_n) begin lat_addr = int'(fl_addr); lat_data = fl_dout; end
        if (!fl_oe_n && prev_oe) begin
            lat_addr = int'(fl_addr);
            fl_din = model_read(lat_addr);
        end
        if (fl_we_n && !prev_we) begin
            model_write(lat_addr, lat_data);
            log_txn(1, lat_addr, int'(lat_data));
        end
        if (fl_oe_n && !prev_oe) begin
            if (mode == 2 && busy > 0) busy--;
            log_txn(0, lat_addr, int'(fl_din));
        end
        if (fl_ce_n && !prev_ce) begin
            chk(low_run == SC, "R10", "strobe width", low_run, SC);
            low_run = 0;
            gap_due = 1;
        end
        prev_we = fl_we_n; prev_oe = fl_oe_n; prev_ce = fl_ce_n;
        if (cyc > 150000) begin
            fails++; checks++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // ---------------- scenario helpers ----------------
    task automatic setup(input int base, input int eb, input int pb,
                         input bit stk, input bit bdev, input int coff);
        fmem.delete();
        for (int i = 0; i < BLK; i++) fmem[base + i] = 8'h0F;
        mode = 0; pend_erase = 0; pend_prog = 0; busy = 0;
        ebusy = eb; pbusy = pb; stuck = stk; bad_dev = bdev;
        corrupt_off = coff; cur_base = base;
        exp_q.delete();
    endtask

    task automatic exp_probe(input int base, input bit id_bad);
        push(1, base, 'hFF, "R2");
        for (int p = 0; p < 2; p++) begin
            push(1, base, 'h90, "R2");
            push(0, 0, 0, "R2");
            push(0, 1, 0, "R2");
            push(1, base, 'hFF, id_bad ? "R3" : "R2");
            if (id_bad) return;
        end
    endtask

    task automatic exp_program(input int base, input bit timeout);
        push(1, base, 'h50, "R4");
        push(1, base, 'hFF, "R4");
        push(1, base, 'h20, "R4");
        push(1, base, 'hD0, "R4");
        if (timeout) begin
            for (int k = 0; k < PL; k++) push(0, base, 0, "R9");
            return;
        end
        for (int k = 0; k <= ebusy; k++) push(0, base, 0, "R5");
        for (int i = 0; i < BLK; i++) begin
            push(1, base, 'h40, "R6");
            push(1, base + i, int'(bufmem[i]), "R6");
            for (int k = 0; k <= pbusy; k++) push(0, base, 0, "R5");
        end
    endtask

    task automatic exp_verify(input int base, input int last_i);
        push(1, base, 'hFF, "R7");
        for (int i = 0; i <= last_i; i++) push(0, base + i, 0, (i == corrupt_off) ? "R8" : "R7");
    endtask

    task automatic run_case(input string tag, input int base, input int exp_code,
                            input int exp_off, input bit poke);
        int  n = 0;
        bit  seen = 0;
        @(negedge clk);
        blk_addr = AW'(base);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        blk_addr = '0;
        while (!seen && n < 60000) begin
            @(negedge clk);
            n++;
            if (poke && n == 400) begin start = 1'b1; blk_addr = 16'hBEEF; end
            else start = 1'b0;
            if (done) seen = 1;
        end
        chk(seen, tag, "done pulse seen", seen, 1);
        chk(err == (exp_code != 0), tag, "err flag", err, exp_code != 0);
        chk(err_code == 2'(exp_code), tag, "err_code", err_code, exp_code);
        if (exp_code == 3) chk(err_offset == OW'(exp_off), "R8", "err_offset", err_offset, exp_off);
        if (exp_code == 2) chk(err_offset == OW'(exp_off), "R9", "err_offset", err_offset, exp_off);
        chk(exp_q.size() == 0, tag, "expected bus cycles left over", exp_q.size(), 0);
        repeat (8) @(negedge clk);
        chk(fl_ce_n && !done, tag, "bus quiet after completion", {fl_ce_n, done}, 2);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        int bad;
        repeat (3) @(negedge clk);
        chk(fl_ce_n && fl_we_n && fl_oe_n, "R1", "strobes high in reset",
            {fl_ce_n, fl_we_n, fl_oe_n}, 7);
        chk(!done && !err && err_code == 0, "R1", "status clear in reset",
            {done, err, err_code}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(fl_ce_n && fl_we_n && fl_oe_n && !done && !err, "R1", "idle after reset",
            {fl_ce_n, fl_we_n, fl_oe_n, done, err}, 5'b11100);

        // success, stride pattern, start poked mid-run (R6 R7 R11)
        for (int i = 0; i < BLK; i++) bufmem[i] = 8'(i * 7 + 3);
        setup('h3400, 3, 1, 0, 0, -1);
        exp_probe('h3400, 0); exp_program('h3400, 0); exp_verify('h3400, BLK - 1);
        run_case("R11", 'h3400, 0, 0, 1);
        bad = 0;
        for (int i = 0; i < BLK; i++)
            if (!fmem.exists('h3400 + i) || fmem['h3400 + i] != bufmem[i]) bad++;
        chk(bad == 0, "R6", "flash contents equal buffer", bad, 0);

        // wrong device identity (R3)
        setup('h1000, 0, 0, 0, 1, -1);
        exp_probe('h1000, 1);
        run_case("R3", 'h1000, 1, 0, 0);

        // device never ready after erase (R9)
        setup('h2000, 0, 0, 1, 0, -1);
        exp_probe('h2000, 0); exp_program('h2000, 1);
        run_case("R9", 'h2000, 2, 0, 0);

        // miscompare on first byte (R8)
        for (int i = 0; i < BLK; i++) bufmem[i] = (i % 2 == 0) ? 8'h55 : 8'hAA;
        setup('h8000, 0, 2, 0, 0, 0);
        exp_probe('h8000, 0); exp_program('h8000, 0); exp_verify('h8000, 0);
        run_case("R8", 'h8000, 3, 0, 0);

        // miscompare on last byte, zero ready delay (R8 R5)
        for (int i = 0; i < BLK; i++) bufmem[i] = 8'(BLK - 1 - i);
        setup('hFF00, 1, 0, 0, 0, BLK - 1);
        exp_probe('hFF00, 0); exp_program('hFF00, 0); exp_verify('hFF00, BLK - 1);
        run_case("R8", 'hFF00, 3, BLK - 1, 0);

        // miscompare in the middle, all-zero data (R8)
        for (int i = 0; i < BLK; i++) bufmem[i] = 8'h00;
        setup('h4500, 2, 1, 0, 0, 37);
        exp_probe('h4500, 0); exp_program('h4500, 0); exp_verify('h4500, 37);
        run_case("R8", 'h4500, 3, 37, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule